// File: doc/BRIEF.md
# Reconfigurable Circular Address Generator

This block produces data-memory addresses for a DSP datapath. It holds four pointers. Each pointer has its own step register and its own wrap-length register, and one shared bias value serves all four. In every cycle the block presents the selected pointer as the address. When an update is requested, it writes back that pointer moved by one of several circular (modulo) stepping rules. The bias can be added after the wrap or folded into the wrapped sum, depending on the rule.

Four stepping rules exist. Only three of them can be reached at a time, through three mode slots. A slot map register says which rule each slot runs, and software can rewrite it while the block is running. A wrap length of zero turns wrapping off, so the pointer then moves by plain 16-bit addition. All registers are loaded through a single write port that has a kind field and an index.

Top module: `circ_agu`

## Requirements
- R1: After reset every pointer, step, wrap length and the bias are zero, and the slot map holds rule 0 in slot 0, rule 2 in slot 1 and rule 3 in slot 2.
- R2: `addr` always shows the pointer selected by `ptrSel` as it stands before any update. A new pointer value appears only after the clock edge that writes it.
- R3: Rule code 0 sets p to ((p + step) mod len) + bias.
- R4: Rule code 1 sets p to ((p + bias) mod len) + 1.
- R5: Rule code 2 sets p to ((p + 1) mod len) + bias.
- R6: Rule code 3 sets p to (p + 1) mod len, so a pointer below a nonzero len stays below it.
- R7: When len is zero, no modulo is applied. The sum is taken 17 bits wide, and the result is kept to 16 bits with the carry dropped.
- R8: With `updEn` high, `modeSel` values 0 to 2 pick the slot whose rule code updates pointer `ptrSel`. `modeSel` = 3 leaves every pointer unchanged.
- R9: `cfgKind` selects the register that a write loads: 0 pointer, 1 step, 2 wrap length, 3 bias, 4 slot map. The slot map takes bits [1:0] for slot 0, [3:2] for slot 1 and [5:4] for slot 2. Kinds 5 to 7 change nothing.
- R10: A configuration write is used from the next cycle on. An update in the same cycle uses the values held before the write. If a pointer write and an update target the same pointer, the write wins.
- R11: An update changes only the pointer selected by `ptrSel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ptrSel | input | 2 | Pointer to present on `addr` and to update |
| modeSel | input | 2 | Mode slot 0 to 2; 3 means hold |
| updEn | input | 1 | Update strobe for the selected pointer |
| cfgWe | input | 1 | Configuration write strobe |
| cfgKind | input | 3 | Register kind written by the configuration port |
| cfgIdx | input | 2 | Pointer index for per-pointer kinds |
| cfgData | input | 16 | Configuration write data |
| addr | output | 16 | Effective address (pre-update pointer) |

## Verification
The bench goes after the wrap boundary, where a pointer one below len must return to zero. An off-by-one compare would instead leave len itself in the pointer. With len zero the pointer must roll over past 0xFFFF: a design that divided by zero, or kept the carry, would show a wrong value. Same-cycle collisions are driven on purpose. A bias or slot-map write in the cycle of an update must not affect that update, and a pointer write must beat an update to the same pointer. Getting either wrong shifts the next address. Random register contents and rule maps cover the folding of the bias inside and outside the modulo.

// File: rtl/circ_agu_pkg.sv
package circ_agu_pkg;

  typedef enum logic [1:0] {
    OP_STEP_WRAP_BIAS = 2'd0,
    OP_BIAS_WRAP_ONE  = 2'd1,
    OP_INC_WRAP_BIAS  = 2'd2,
    OP_INC_WRAP       = 2'd3
  } agu_op_e;

  localparam logic [2:0] KIND_PTR  = 3'd0;
  localparam logic [2:0] KIND_STEP = 3'd1;
  localparam logic [2:0] KIND_LEN  = 3'd2;
  localparam logic [2:0] KIND_BIAS = 3'd3;
  localparam logic [2:0] KIND_MAP  = 3'd4;

  localparam int SLOTS    = 3;
  localparam int MAP_W    = 2 * SLOTS;
  localparam logic [MAP_W-1:0] MAP_RESET = {OP_INC_WRAP, OP_INC_WRAP_BIAS, OP_STEP_WRAP_BIAS};

  typedef struct packed {
    logic    upd;
    agu_op_e op;
    logic    wrPtr;
    logic    wrStep;
    logic    wrLen;
    logic    wrBias;
  } agu_strb_t;

endpackage

// File: rtl/circ_agu_ctrl.sv
module circ_agu_ctrl
  import circ_agu_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       modeSel,
  input  logic             updEn,
  input  logic             cfgWe,
  input  logic [2:0]       cfgKind,
  input  logic [MAP_W-1:0] cfgMap,
  output agu_strb_t        strb
);

  logic [MAP_W-1:0] mapQ;
  logic             mapWr;
  agu_op_e          slotOp [SLOTS];

  assign mapWr = cfgWe && (cfgKind == KIND_MAP);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      mapQ <= MAP_RESET;
    else if (mapWr) mapQ <= cfgMap;
  end

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    assign slotOp[s] = agu_op_e'(mapQ[2*s +: 2]);
  end

  always_comb begin
    strb        = '0;
    strb.upd    = updEn && (modeSel < 2'(SLOTS));
    strb.op     = (modeSel < 2'(SLOTS)) ? slotOp[modeSel] : OP_INC_WRAP;
    strb.wrPtr  = cfgWe && (cfgKind == KIND_PTR);
    strb.wrStep = cfgWe && (cfgKind == KIND_STEP);
    strb.wrLen  = cfgWe && (cfgKind == KIND_LEN);
    strb.wrBias = cfgWe && (cfgKind == KIND_BIAS);
  end

  // R9: at most one register kind is written per cycle
  p_onehot_wr_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrPtr, strb.wrStep, strb.wrLen, strb.wrBias, mapWr}));

  // R10: slot map only moves on its own write
  p_map_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !mapWr |=> $stable(mapQ));

  // R8: hold mode never raises an update
  p_hold_mode_r8: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 2'd3) |-> !strb.upd);

endmodule

// File: rtl/circ_agu_dp.sv
module circ_agu_dp
  import circ_agu_pkg::*;
#(
  parameter int NPTR  = 4,
  parameter int W     = 16,
  parameter int IDX_W = $clog2(NPTR)
) (
  input  logic             clk,
  input  logic             rstN,
  input  agu_strb_t        strb,
  input  logic [IDX_W-1:0] updIdx,
  input  logic [IDX_W-1:0] cfgIdx,
  input  logic [W-1:0]     cfgData,
  output logic [W-1:0]     addr
);

  logic [NPTR-1:0][W-1:0] ptrQ;
  logic [NPTR-1:0][W-1:0] stepQ;
  logic [NPTR-1:0][W-1:0] lenQ;
  logic [W-1:0]           biasQ;

  logic [W-1:0] curPtr, curStep, curLen, postAdd, nextVal;
  logic [W:0]   preSum, divisor, wrapped;

  assign curPtr  = ptrQ[updIdx];
  assign curStep = stepQ[updIdx];
  assign curLen  = lenQ[updIdx];
  assign addr    = ptrQ[updIdx];

  always_comb begin
    unique case (strb.op)
      OP_STEP_WRAP_BIAS: begin preSum = {1'b0, curPtr} + {1'b0, curStep}; postAdd = biasQ; end
      OP_BIAS_WRAP_ONE:  begin preSum = {1'b0, curPtr} + {1'b0, biasQ};   postAdd = W'(1);  end
      OP_INC_WRAP_BIAS:  begin preSum = {1'b0, curPtr} + (W+1)'(1);       postAdd = biasQ; end
      default:           begin preSum = {1'b0, curPtr} + (W+1)'(1);       postAdd = '0;    end
    endcase
    divisor = (curLen == '0) ? (W+1)'(1) : {1'b0, curLen};
    wrapped = (curLen == '0) ? preSum : (preSum % divisor);
    nextVal = wrapped[W-1:0] + postAdd;
  end

  for (genvar i = 0; i < NPTR; i++) begin : g_ptr
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        ptrQ[i]  <= '0;
        stepQ[i] <= '0;
        lenQ[i]  <= '0;
      end else begin
        if (strb.wrPtr && cfgIdx == IDX_W'(i))     ptrQ[i] <= cfgData;
        else if (strb.upd && updIdx == IDX_W'(i))  ptrQ[i] <= nextVal;
        if (strb.wrStep && cfgIdx == IDX_W'(i))    stepQ[i] <= cfgData;
        if (strb.wrLen && cfgIdx == IDX_W'(i))     lenQ[i]  <= cfgData;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            biasQ <= '0;
    else if (strb.wrBias) biasQ <= cfgData;
  end

  // R6: stepping by one inside a nonzero length stays inside it
  p_wrap_bound_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.upd && strb.op == OP_INC_WRAP && curLen != '0) |-> (nextVal < curLen));

  // R7: zero length gives plain 16-bit increment
  p_linear_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.upd && strb.op == OP_INC_WRAP && curLen == '0 && !strb.wrPtr)
      |=> ptrQ[$past(updIdx)] == W'($past(curPtr) + W'(1)));

  // R11: without update or pointer write, no pointer moves
  p_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.upd && !strb.wrPtr) |=> $stable(ptrQ));

endmodule

// File: rtl/circ_agu.sv
module circ_agu
  import circ_agu_pkg::*;
#(
  parameter int NPTR  = 4,
  parameter int W     = 16,
  parameter int IDX_W = $clog2(NPTR)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [IDX_W-1:0] ptrSel,
  input  logic [1:0]       modeSel,
  input  logic             updEn,
  input  logic             cfgWe,
  input  logic [2:0]       cfgKind,
  input  logic [IDX_W-1:0] cfgIdx,
  input  logic [W-1:0]     cfgData,
  output logic [W-1:0]     addr
);

  agu_strb_t strb;

  circ_agu_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .modeSel (modeSel),
    .updEn   (updEn),
    .cfgWe   (cfgWe),
    .cfgKind (cfgKind),
    .cfgMap  (cfgData[MAP_W-1:0]),
    .strb    (strb)
  );

  circ_agu_dp #(.NPTR(NPTR), .W(W), .IDX_W(IDX_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .updIdx  (ptrSel),
    .cfgIdx  (cfgIdx),
    .cfgData (cfgData),
    .addr    (addr)
  );

endmodule

// File: tb/circ_agu_tb.sv
`timescale 1ns/1ps
module circ_agu_tb;

  logic        clk = 0;
  logic        rstN = 0;
  logic [1:0]  ptrSel = 0, modeSel = 0, cfgIdx = 0;
  logic        updEn = 0, cfgWe = 0;
  logic [2:0]  cfgKind = 0;
  logic [15:0] cfgData = 0;
  logic [15:0] addr;

  int checks = 0, errors = 0;

  logic [15:0] mPtr [4];
  logic [15:0] mStep [4];
  logic [15:0] mLen [4];
  logic [15:0] mBias;
  logic [1:0]  mMap [3];

  always #2 clk = ~clk;

  circ_agu u_dut (.clk(clk), .rstN(rstN), .ptrSel(ptrSel), .modeSel(modeSel),
    .updEn(updEn), .cfgWe(cfgWe), .cfgKind(cfgKind), .cfgIdx(cfgIdx),
    .cfgData(cfgData), .addr(addr));

  function automatic logic [15:0] refNext(logic [1:0] op, logic [15:0] p,
      logic [15:0] s, logic [15:0] l, logic [15:0] b);
    logic [16:0] sum, wr;
    logic [15:0] post;
    case (op)
      2'd0: begin sum = 17'(p) + 17'(s); post = b; end
      2'd1: begin sum = 17'(p) + 17'(b); post = 16'd1; end
      2'd2: begin sum = 17'(p) + 17'd1; post = b; end
      default: begin sum = 17'(p) + 17'd1; post = 16'd0; end
    endcase
    wr = (l == 0) ? sum : sum % 17'(l);
    return wr[15:0] + post;
  endfunction

  task automatic check(string tag, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s addr=%h expected=%h", tag, got, exp);
    end
  endtask

  // drive one cycle; check addr before the edge, then advance the model
  task automatic doCycle(string tag, logic [1:0] ps, logic [1:0] ms, logic up,
      logic we, logic [2:0] kind, logic [1:0] idx, logic [15:0] data);
    logic [15:0] nv;
    logic doUpd;
    @(negedge clk);
    ptrSel = ps; modeSel = ms; updEn = up; cfgWe = we;
    cfgKind = kind; cfgIdx = idx; cfgData = data;
    #1 check(tag, addr, mPtr[ps]);
    doUpd = up && (ms != 2'd3);
    nv = 0;
    if (doUpd) nv = refNext(mMap[ms], mPtr[ps], mStep[ps], mLen[ps], mBias);
    @(posedge clk);
    if (doUpd && !(we && kind == 3'd0 && idx == ps)) mPtr[ps] = nv;
    if (we) case (kind)
      3'd0: mPtr[idx] = data;
      3'd1: mStep[idx] = data;
      3'd2: mLen[idx] = data;
      3'd3: mBias = data;
      3'd4: begin mMap[0] = data[1:0]; mMap[1] = data[3:2]; mMap[2] = data[5:4]; end
      default: ;
    endcase
  endtask

  task automatic wr(logic [2:0] kind, logic [1:0] idx, logic [15:0] data);
    doCycle("R9 write", 0, 3, 0, 1, kind, idx, data);
  endtask

  task automatic readAll(string tag);
    for (int i = 0; i < 4; i++) doCycle(tag, 2'(i), 3, 0, 0, 0, 0, 0);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin mPtr[i] = 0; mStep[i] = 0; mLen[i] = 0; end
    mBias = 0; mMap[0] = 0; mMap[1] = 2; mMap[2] = 3;
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1;

    readAll("R1 reset pointer");

    // R8 default map: slot0 rule0, slot1 rule2, slot2 rule3
    wr(0, 0, 16'd5); wr(3, 0, 16'h0010);
    doCycle("R8", 0, 0, 1, 0, 0, 0, 0);
    doCycle("R8 slot0 rule0", 0, 1, 1, 0, 0, 0, 0);
    doCycle("R8 slot1 rule2", 0, 2, 1, 0, 0, 0, 0);
    doCycle("R8 slot2 rule3", 0, 3, 1, 0, 0, 0, 0);
    doCycle("R8 hold mode", 0, 3, 0, 0, 0, 0, 0);

    // R3 with wrap: p=7 step=5 len=10 bias=100 -> 102
    wr(0, 1, 16'd7); wr(1, 1, 16'd5); wr(2, 1, 16'd10); wr(3, 0, 16'd100);
    doCycle("R3", 1, 0, 1, 0, 0, 0, 0);
    doCycle("R3 result", 1, 3, 0, 0, 0, 0, 0);
    check("R3 directed", addr, 16'd102);

    // R6 boundary: p=9 len=10 -> 0
    wr(0, 2, 16'd9); wr(2, 2, 16'd10);
    doCycle("R6", 2, 2, 1, 0, 0, 0, 0);
    doCycle("R6 wrap to zero", 2, 3, 0, 0, 0, 0, 0);
    check("R6 directed", addr, 16'd0);
    readAll("R11 others unchanged");

    // R7 zero length rolls over
    wr(0, 3, 16'hFFFF); wr(2, 3, 16'd0);
    doCycle("R7", 3, 2, 1, 0, 0, 0, 0);
    doCycle("R7 rollover", 3, 3, 0, 0, 0, 0, 0);
    check("R7 directed", addr, 16'd0);

    // R4 and R5 via map rewrite
    wr(4, 0, 16'b10_01_01);
    doCycle("R4", 1, 0, 1, 0, 0, 0, 0);
    doCycle("R5", 1, 2, 1, 0, 0, 0, 0);
    doCycle("R5 result", 1, 3, 0, 0, 0, 0, 0);

    // R9 ignored kinds
    wr(5, 0, 16'hAAAA); wr(6, 1, 16'h5555); wr(7, 2, 16'h1234);
    readAll("R9 ignored kind");
    doCycle("R9 map unchanged", 0, 0, 1, 0, 0, 0, 0);

    // R10 same-cycle bias write uses old bias; map write uses old map
    doCycle("R10", 0, 2, 1, 1, 3, 0, 16'h0700);
    doCycle("R10 old bias", 0, 0, 1, 1, 4, 0, 16'b11_11_11);
    doCycle("R10 old map", 0, 0, 1, 0, 0, 0, 0);
    // R10 pointer write beats update on same pointer
    doCycle("R10", 2, 1, 1, 1, 0, 2, 16'h4321);
    doCycle("R10 write wins", 2, 3, 0, 0, 0, 0, 0);
    check("R10 directed", addr, 16'h4321);

    // random mix
    for (int n = 0; n < 400; n++) begin
      logic we;
      logic [2:0] kind;
      logic [15:0] data;
      we = ($urandom % 4) == 0;
      kind = 3'($urandom % 8);
      data = 16'($urandom);
      if (kind == 3'd2 && ($urandom % 3) != 0) data = 16'($urandom % 40);
      if (kind == 3'd2 && ($urandom % 4) == 0) data = 0;
      doCycle("R2 R3 R4 R5 R6 random", 2'($urandom), 2'($urandom), 1'($urandom),
              we, kind, 2'($urandom), data);
    end
    readAll("R2 final");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule